// File: doc/BRIEF.md
# I2S Transmit Clock Generator

This block produces the timing events for the transmit half of an I2S port. It runs entirely in the peripheral clock domain. Each generated clock is a one-cycle enable pulse, not a toggling wire. A fractional rate stage turns the peripheral clock into a pulse stream whose average rate is X/Y. A fixed halving stage follows it and gives the transmit reference, which can also be sent out as the master clock. A programmable integer divider turns the selected reference into bit-clock ticks. A word counter turns those ticks into the word-select level.

A source selector decides where the bit timing comes from. It can come from the block's own fractional reference, or from the receiver's reference pulse in place of it. In the third setting the receiver's bit-clock tick and word select are passed straight through and the local dividers are bypassed. A slave control makes word select follow an external pin instead of the local counter, and releases the pin drive enable. A separate control decides whether the master clock is driven.

Top module: `i2s_tx_clkgen`

## Requirements
- R1: While reset is held and in the first cycle after it, `mclk_en` and `bclk_tick` are 0 and `ws` is 0.
- R2: When 0 < `rate_num` <= `rate_den`, the fractional stage emits pulses at an average rate of `rate_num`/`rate_den` per peripheral cycle. When `rate_num` is 0 or greater than `rate_den`, it emits none, so no reference, master clock or locally derived bit tick appears.
- R3: The own reference is every second fractional pulse, with an average rate of X/(2Y). It is never high in two consecutive cycles.
- R4: When `mclk_drive` is 1, `mclk_en` carries the own reference pulses. When it is 0, `mclk_en` stays 0. `mclk_oe` equals `mclk_drive`.
- R5: One `bclk_tick` is produced for every N selected reference pulses, where N = `bit_div_sel` + 1 (0 gives 1, 63 gives 64). The tick is registered and appears the cycle after the Nth pulse.
- R6: With `src_sel` = 1, the selected reference is `rx_ref_en`. The fractional settings then have no effect on `bclk_tick`. A cycle without `rx_ref_en` is followed by a cycle without a tick.
- R7: With `src_sel` = 2 (4-wire), `bclk_tick` equals `rx_bclk_en` in the same cycle and `ws` equals `rx_ws`. `src_sel` = 0 and 3 both select the own reference.
- R8: In the local word counter, `ws` toggles after every L = `ws_len_sel` + 1 divider ticks. It changes only in the cycle after a tick (the falling-edge event) or after a source change.
- R9: With `slave_mode` = 1 (and `src_sel` not 2), `ws` follows `ext_ws` and `pins_oe` is 0. With `slave_mode` = 0, `pins_oe` is 1.
- R10: A change of `src_sel` restarts the bit divider and word counter. No tick appears in the cycle after the change, and the first new tick comes only after N full pulses of the new source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_num | input | 8 | Fractional numerator X |
| rate_den | input | 8 | Fractional denominator Y |
| bit_div_sel | input | 6 | Bit divider setting, N = value + 1 |
| ws_len_sel | input | 6 | Bit ticks per channel minus one |
| src_sel | input | 2 | 0/3 own reference, 1 receiver reference, 2 receiver bit clock and word select |
| slave_mode | input | 1 | 1 = word select taken from `ext_ws` |
| mclk_drive | input | 1 | Enables the master clock output |
| rx_ref_en | input | 1 | Receiver reference pulse |
| rx_bclk_en | input | 1 | Receiver bit-clock tick |
| rx_ws | input | 1 | Receiver word select |
| ext_ws | input | 1 | Word select from the external master |
| mclk_en | output | 1 | Master clock pulse |
| mclk_oe | output | 1 | Master clock pin drive enable |
| bclk_tick | output | 1 | Bit-clock falling-edge event |
| ws | output | 1 | Word select level |
| pins_oe | output | 1 | Bit clock and word select pin drive enable |

## Verification
A source switch can land in the same cycle as a bit-divider tick or a word-select toggle that the old source would have produced. The restart has to win over both. The bench provokes this by moving from the own reference to the receiver reference while both run at the same pulse spacing. It then counts the cycles from the switch to the first tick and requires at least the full N-pulse distance. Mean rates for several X/Y/N/L settings are judged by pulse counts over long windows, held against values computed from the ratios.

// File: rtl/i2s_txclk_pkg.sv
package i2s_txclk_pkg;

  typedef enum logic [1:0] {
    SRC_OWN   = 2'd0,
    SRC_RXREF = 2'd1,
    SRC_RX4W  = 2'd2,
    SRC_ALT   = 2'd3
  } src_e;

  // a fractional setting is usable only with 0 < num <= den
  function automatic logic frac_cfg_ok(input logic [7:0] num, input logic [7:0] den);
    return (num != 8'd0) && (num <= den);
  endfunction

  // terminal count test shared by the two counters
  function automatic logic at_terminal(input logic [5:0] cnt, input logic [5:0] lim);
    return cnt >= lim;
  endfunction

endpackage

// File: rtl/txclk_frac.sv
module txclk_frac
  import i2s_txclk_pkg::*;
#(
  parameter int RATE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RATE_W-1:0] num,
  input  logic [RATE_W-1:0] den,
  output logic              frac_pulse,
  output logic              ref_pulse
);
  localparam int ACC_W = RATE_W + 1;

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] sum;
  logic             cfg_ok;
  logic             pulse_q;
  logic             half_q;

  assign cfg_ok = frac_cfg_ok(num, den);
  assign sum    = acc_q + ACC_W'(num);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q   <= '0;
      pulse_q <= 1'b0;
      half_q  <= 1'b0;
    end else if (!cfg_ok) begin
      acc_q   <= '0;
      pulse_q <= 1'b0;
      half_q  <= 1'b0;
    end else begin
      if (sum >= ACC_W'(den)) begin
        acc_q   <= sum - ACC_W'(den);
        pulse_q <= 1'b1;
      end else begin
        acc_q   <= sum;
        pulse_q <= 1'b0;
      end
      if (pulse_q) half_q <= ~half_q;
    end
  end

  assign frac_pulse = pulse_q;
  assign ref_pulse  = pulse_q & half_q;

  // R2: a fractional pulse only follows a cycle with a usable setting
  a_r2_quiet_when_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    frac_pulse |-> $past(cfg_ok));

  // R3: halved reference is never high two cycles in a row
  a_r3_ref_spaced: assert property (@(posedge clk) disable iff (!rst_n)
    ref_pulse |=> !ref_pulse);

endmodule

// File: rtl/txclk_bitdiv.sv
module txclk_bitdiv
  import i2s_txclk_pkg::*;
#(
  parameter int NDIV_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              restart,
  input  logic [NDIV_W-1:0] n_sel,
  output logic              tick
);
  logic [NDIV_W-1:0] cnt_q;
  logic              tick_q;

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (step) begin
      if (at_terminal(cnt_q, n_sel)) begin
        cnt_q  <= '0;
        tick_q <= 1'b1;
      end else begin
        cnt_q  <= cnt_q + 1'b1;
        tick_q <= 1'b0;
      end
    end else begin
      tick_q <= 1'b0;
    end
  end

  assign tick = tick_q;

  // R5: every tick is caused by a reference step one cycle earlier
  a_r5_tick_after_step: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> $past(step));

  // R10: a restart suppresses the following tick
  a_r10_no_tick_after_restart: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !tick);

endmodule

// File: rtl/txclk_wsgen.sv
module txclk_wsgen
  import i2s_txclk_pkg::*;
#(
  parameter int WSLEN_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               restart,
  input  logic [WSLEN_W-1:0] len_sel,
  output logic               ws
);
  logic [WSLEN_W-1:0] wcnt_q;
  logic               ws_q;

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      wcnt_q <= '0;
      ws_q   <= 1'b0;
    end else if (tick) begin
      if (at_terminal(wcnt_q, len_sel)) begin
        wcnt_q <= '0;
        ws_q   <= ~ws_q;
      end else begin
        wcnt_q <= wcnt_q + 1'b1;
      end
    end
  end

  assign ws = ws_q;

  // R8: word select moves only after a tick or a restart
  a_r8_ws_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (ws_q != $past(ws_q)) |-> $past(tick || restart));

endmodule

// File: rtl/i2s_tx_clkgen.sv
module i2s_tx_clkgen
  import i2s_txclk_pkg::*;
#(
  parameter int RATE_W  = 8,
  parameter int NDIV_W  = 6,
  parameter int WSLEN_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [RATE_W-1:0]  rate_num,
  input  logic [RATE_W-1:0]  rate_den,
  input  logic [NDIV_W-1:0]  bit_div_sel,
  input  logic [WSLEN_W-1:0] ws_len_sel,
  input  logic [1:0]         src_sel,
  input  logic               slave_mode,
  input  logic               mclk_drive,
  input  logic               rx_ref_en,
  input  logic               rx_bclk_en,
  input  logic               rx_ws,
  input  logic               ext_ws,
  output logic               mclk_en,
  output logic               mclk_oe,
  output logic               bclk_tick,
  output logic               ws,
  output logic               pins_oe
);
  src_e src_q;
  logic restart;
  logic own_frac;
  logic own_ref;
  logic use_rxref;
  logic use_4w;
  logic sel_ref;
  logic div_step;
  logic div_tick;
  logic local_ws;

  always_ff @(posedge clk) begin
    if (!rst_n) src_q <= SRC_OWN;
    else        src_q <= src_e'(src_sel);
  end

  assign restart   = (src_e'(src_sel) != src_q);
  assign use_rxref = (src_q == SRC_RXREF);
  assign use_4w    = (src_q == SRC_RX4W);

  txclk_frac #(.RATE_W(RATE_W)) u_frac (
    .clk        (clk),
    .rst_n      (rst_n),
    .num        (rate_num),
    .den        (rate_den),
    .frac_pulse (own_frac),
    .ref_pulse  (own_ref)
  );

  assign sel_ref  = use_rxref ? rx_ref_en : own_ref;
  assign div_step = sel_ref & ~use_4w;

  txclk_bitdiv #(.NDIV_W(NDIV_W)) u_bitdiv (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (div_step),
    .restart (restart),
    .n_sel   (bit_div_sel),
    .tick    (div_tick)
  );

  txclk_wsgen #(.WSLEN_W(WSLEN_W)) u_wsgen (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (div_tick),
    .restart (restart),
    .len_sel (ws_len_sel),
    .ws      (local_ws)
  );

  assign mclk_en   = own_ref & mclk_drive;
  assign mclk_oe   = mclk_drive;
  assign bclk_tick = use_4w ? rx_bclk_en : div_tick;
  assign ws        = use_4w ? rx_ws : (slave_mode ? ext_ws : local_ws);
  assign pins_oe   = ~slave_mode;

  // R6: with the receiver reference selected, no pulse means no tick next cycle
  a_r6_rxref_drives_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (use_rxref && !restart && !rx_ref_en) |=> (!bclk_tick || use_4w));

  // R4: master clock pulses only exist while a fractional pulse is present
  a_r4_mclk_from_frac: assert property (@(posedge clk) disable iff (!rst_n)
    mclk_en |-> own_frac);

endmodule

// File: tb/i2s_tx_clkgen_tb_top.sv
`timescale 1ns/1ps
module i2s_tx_clkgen_tb_top;

  typedef struct {
    string tag;
    int    lo[3];
    int    hi[3];
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] rate_num = 8'd1, rate_den = 8'd2;
  logic [5:0] bit_div_sel = '0, ws_len_sel = '0;
  logic [1:0] src_sel = 2'd0;
  logic       slave_mode = 1'b0, mclk_drive = 1'b1;
  logic       rx_ref_en = 1'b0, rx_bclk_en = 1'b0, rx_ws = 1'b0, ext_ws = 1'b0;
  logic       mclk_en, mclk_oe, bclk_tick, ws, pins_oe;

  int checks = 0, errors = 0;
  int ref_period = 0, bclk_period = 0;
  int mc = 0, bc = 0, wc = 0;
  logic win = 1'b0, win_end = 1'b0, prev_ws = 1'b0;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  i2s_tx_clkgen dut_i (
    .clk(clk), .rst_n(rst_n), .rate_num(rate_num), .rate_den(rate_den),
    .bit_div_sel(bit_div_sel), .ws_len_sel(ws_len_sel), .src_sel(src_sel),
    .slave_mode(slave_mode), .mclk_drive(mclk_drive), .rx_ref_en(rx_ref_en),
    .rx_bclk_en(rx_bclk_en), .rx_ws(rx_ws), .ext_ws(ext_ws),
    .mclk_en(mclk_en), .mclk_oe(mclk_oe), .bclk_tick(bclk_tick), .ws(ws),
    .pins_oe(pins_oe)
  );

  // receiver-side pulse generator
  initial begin
    int rc = 0, bcn = 0, wsn = 0;
    forever begin
      @(posedge clk); #1;
      rc++; bcn++;
      rx_ref_en  = (ref_period > 0) && (rc % ref_period == 0);
      rx_bclk_en = (bclk_period > 0) && (bcn % bclk_period == 0);
      if (rx_bclk_en) begin
        wsn++;
        if (wsn % 8 == 0) rx_ws = ~rx_ws;
      end
    end
  end

  task automatic check(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  // monitor: counts events in the window and compares against the queued item
  always @(negedge clk) begin
    if (win) begin
      if (mclk_en) mc++;
      if (bclk_tick) bc++;
      if (ws != prev_ws) wc++;
    end
    prev_ws = ws;
    if (win_end && sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check({e.tag, " mclk"}, mc, e.lo[0], e.hi[0]);
      check({e.tag, " bclk"}, bc, e.lo[1], e.hi[1]);
      check({e.tag, " ws"},   wc, e.lo[2], e.hi[2]);
      win_end = 1'b0;
    end
  end

  function automatic int own_ref_cnt(int w, int x, int y);
    if (x == 0 || x > y) return 0;
    return (w * x) / (2 * y);
  endfunction

  function automatic int own_bclk_cnt(int w, int x, int y, int n);
    if (x == 0 || x > y) return 0;
    return (w * x) / (2 * y * (n + 1));
  endfunction

  task automatic run_window(input string tag, input int w,
                            input int m, input int mt, input int b, input int bt,
                            input int s, input int st);
    exp_t e;
    repeat (300) @(posedge clk);
    e.tag = tag;
    e.lo[0] = m - mt; e.hi[0] = m + mt;
    e.lo[1] = b - bt; e.hi[1] = b + bt;
    e.lo[2] = s - st; e.hi[2] = s + st;
    sb.push_back(e);
    @(posedge clk); #1;
    mc = 0; bc = 0; wc = 0; win = 1'b1;
    repeat (w) @(posedge clk);
    #1; win = 1'b0; win_end = 1'b1;
    while (win_end) @(posedge clk);
  endtask

  task automatic own_case(input string tag, input int w, input int x, input int y,
                          input int n, input int l);
    int r, b;
    rate_num = 8'(x); rate_den = 8'(y); bit_div_sel = 6'(n); ws_len_sel = 6'(l);
    r = own_ref_cnt(w, x, y);
    b = own_bclk_cnt(w, x, y, n);
    run_window(tag, w, mclk_drive ? r : 0, 2, b, 2, b / (l + 1), 2);
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual 1 expected 0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int first_k;
    // R1 reset state
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R1 mclk in reset", int'(mclk_en), 0, 0);
    check("R1 bclk in reset", int'(bclk_tick), 0, 0);
    check("R1 ws in reset", int'(ws), 0, 0);
    @(posedge clk); #1; rst_n = 1'b1;
    @(negedge clk);
    check("R1 mclk after reset", int'(mclk_en), 0, 0);
    check("R1 ws after reset", int'(ws), 0, 0);
    check("R9 pins_oe master", int'(pins_oe), 1, 1);
    check("R4 mclk_oe follows drive", int'(mclk_oe), 1, 1);

    // R2 R3 R5 R8 own reference at several settings
    own_case("R2 R3 R5 R8 X1/Y2 N1 L16", 4000, 1, 2, 0, 15);
    own_case("R2 R3 R5 R8 X3/Y7 N3 L4", 14000, 3, 7, 2, 3);
    own_case("R2 R3 R5 R8 X5/Y5 N64 L1", 12800, 5, 5, 63, 0);

    // R2 invalid settings give nothing
    own_case("R2 X0", 3000, 0, 9, 0, 0);
    own_case("R2 X9>Y4", 3000, 9, 4, 0, 0);

    // R4 master clock gated off
    @(posedge clk); #1; mclk_drive = 1'b0;
    @(negedge clk);
    check("R4 mclk_oe low", int'(mclk_oe), 0, 0);
    own_case("R4 mclk off X1/Y2", 4000, 1, 2, 0, 1);
    @(posedge clk); #1; mclk_drive = 1'b1;

    // R6 receiver reference, own settings invalid
    @(posedge clk); #1;
    rate_num = 8'd0; rate_den = 8'd5; bit_div_sel = 6'd1; ws_len_sel = 6'd9;
    ref_period = 5; src_sel = 2'd1;
    run_window("R6 rx ref /5 N2 L10", 10000, 0, 0, 1000, 2, 100, 2);

    // R7 4-wire pass-through
    @(posedge clk); #1;
    rate_num = 8'd1; rate_den = 8'd2; bclk_period = 3; src_sel = 2'd2;
    run_window("R7 4-wire", 9000, 2250, 2, 3000, 1, 375, 2);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (i % 10 == 0) check("R7 ws equals rx_ws", int'(ws), int'(rx_ws), int'(rx_ws));
    end

    // R9 slave: ws from ext_ws
    @(posedge clk); #1; src_sel = 2'd0; slave_mode = 1'b1; ext_ws = 1'b1;
    @(negedge clk);
    check("R9 pins_oe slave", int'(pins_oe), 0, 0);
    check("R9 ws follows ext high", int'(ws), 1, 1);
    @(posedge clk); #1; ext_ws = 1'b0;
    @(negedge clk);
    check("R9 ws follows ext low", int'(ws), 0, 0);
    @(posedge clk); #1; slave_mode = 1'b0;

    // R10 switch own -> rx ref at equal pulse spacing
    @(posedge clk); #1;
    rate_num = 8'd1; rate_den = 8'd1; bit_div_sel = 6'd3; ref_period = 2;
    repeat (300) @(posedge clk);
    for (int t = 0; t < 4; t++) begin
      @(posedge clk); #1; src_sel = (t % 2 == 0) ? 2'd1 : 2'd0;
      @(negedge clk);
      first_k = 0;
      for (int k = 1; k <= 20; k++) begin
        @(negedge clk);
        if (bclk_tick && first_k == 0) first_k = k;
      end
      check("R10 first tick after switch", first_k, 8, 12);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule